// File: doc/BRIEF.md
# General-Purpose Pin Controller with Per-Line Interrupts

This block controls 32 general-purpose pins through a small word-wide register bus. Software sets a direction for each pin and drives output pins from an output data register. That register can be written whole, or changed bit by bit through a set alias and a clear alias. The level of every pin can be read back after it has passed through a synchroniser, so that asynchronous pad inputs never reach the logic directly.

The sixteen lowest pins each have a dedicated interrupt wire to a parent interrupt controller. There is no shared status or clear register. A mode bit per line selects between two behaviours. In level mode the wire carries the synchronised pin, and the line's output data bit inverts it when set. In both-edge mode the wire gives a one-cycle pulse for every change of the synchronised pin.

The bus is a plain select/write strobe with a byte address. Writes take effect on the clock edge where they are sampled. Read data is combinational while a read is selected and is zero otherwise.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction, output data and mode registers read 0, `pad_oe` and `pad_out` are 0, and `irq_out` is 0 while the pads are low.
- R2: The direction register is at byte offset 0x00, and its reads return the last value written. A 1 in a bit drives `pad_oe` high for that pin from the cycle after the write.
- R3: Offset 0x08 returns the pad levels through a two-flop synchroniser. A pad change becomes readable two clock edges after it is applied. Writes to 0x08 change nothing.
- R4: The output data register is at offset 0x10. All 32 bits read back as last written, and `pad_out` equals this register.
- R5: Writing offset 0x18 sets each output data bit whose write bit is 1 and leaves the others unchanged. Reads of 0x18 return 0.
- R6: Writing offset 0x20 clears each output data bit whose write bit is 1 and leaves the others unchanged. Reads of 0x20 return 0.
- R7: The mode register is at offset 0x30 and stores bits 15:0, one per interrupt line. Bits 31:16 always read 0.
- R8: When mode bit n is 0 and output data bit n is 0, `irq_out[n]` equals the synchronised pin n, one clock edge after the synchroniser output (three edges after the pad change).
- R9: When mode bit n is 0 and output data bit n is 1, `irq_out[n]` is the inverse of the synchronised pin n, with the same latency as R8.
- R10: When mode bit n is 1, `irq_out[n]` is high for exactly one cycle after each change of the synchronised pin n, and output data bit n has no effect. Switching into this mode while the pin is steady gives no pulse.
- R11: Pins 16 to 31 raise no interrupt. Only lines 0 to 15 exist, and toggling the upper pins leaves `irq_out` unchanged.
- R12: Offsets not listed in R2 to R7 read 0, and writes to them leave every register unchanged.
- R13: If a register write and a synchronised pin change land on the same clock edge, the next `irq_out` value is formed from the new register value and the new pin level together. A simultaneous pin rise and polarity set therefore leaves a low line low. A pin edge on the edge that enables both-edge mode is reported as a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is selected |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_out | output | 16 | One interrupt wire per low pin |

## Verification
A register write and a synchronised pin transition can both land on one clock edge. Both feed the registered interrupt line, so the ordering between them is the main hazard. The bench applies a pad change one cycle ahead, so that the synchroniser output flips on exactly the edge that samples a polarity or mode write. It then samples `irq_out` at the three following falling edges. In level mode the line must stay low when pin and polarity flip together. When the mode write coincides with a pin edge, exactly one pulse must appear, in the cycle after that edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets decoded by the register file
  localparam logic [31:0] OFS_DIR  = 32'h00;
  localparam logic [31:0] OFS_IN   = 32'h08;
  localparam logic [31:0] OFS_OUT  = 32'h10;
  localparam logic [31:0] OFS_SET  = 32'h18;
  localparam logic [31:0] OFS_CLR  = 32'h20;
  localparam logic [31:0] OFS_MODE = 32'h30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_IN,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_MODE
  } reg_sel_e;

  // Address to register selector; anything unlisted maps to SEL_NONE
  function automatic reg_sel_e f_decode(input logic [31:0] addr);
    case (addr)
      OFS_DIR:  return SEL_DIR;
      OFS_IN:   return SEL_IN;
      OFS_OUT:  return SEL_OUT;
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_MODE: return SEL_MODE;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Next value of one output data bit for a given access
  function automatic logic f_out_next(input reg_sel_e sel, input logic wr_en,
                                      input logic cur, input logic wbit);
    if (!wr_en) return cur;
    case (sel)
      SEL_OUT: return wbit;
      SEL_SET: return cur | wbit;
      SEL_CLR: return cur & ~wbit;
      default: return cur;
    endcase
  endfunction

  // Next interrupt wire value: edge detector in both-edge mode, else polarity XOR
  function automatic logic f_irq_next(input logic both, input logic pol,
                                      input logic lvl, input logic prev);
    return both ? (lvl ^ prev) : (lvl ^ pol);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] in_lvl,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_IRQ-1:0]  mode_q
);

  reg_sel_e             sel_w;
  logic                 wr_en;
  logic                 rd_en;
  logic [NUM_PINS-1:0]  out_d;

  assign sel_w = f_decode(32'(addr));
  assign wr_en = sel & wr;
  assign rd_en = sel & ~wr;

  // Direction register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        dir_q <= '0;
    else if (wr_en && sel_w == SEL_DIR) dir_q <= wdata[NUM_PINS-1:0];
  end

  // Output data: whole write, set alias, clear alias
  generate
    for (genvar b = 0; b < NUM_PINS; b++) begin : g_out_bit
      assign out_d[b] = f_out_next(sel_w, wr_en, out_q[b], wdata[b]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  // Interrupt mode bits, one per interrupt-capable line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode_q <= '0;
    else if (wr_en && sel_w == SEL_MODE) mode_q <= wdata[NUM_IRQ-1:0];
  end

  // Read multiplexer; aliases and holes return zero
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel_w)
        SEL_DIR:  rdata[NUM_PINS-1:0] = dir_q;
        SEL_IN:   rdata[NUM_PINS-1:0] = in_lvl;
        SEL_OUT:  rdata[NUM_PINS-1:0] = out_q;
        SEL_MODE: rdata[NUM_IRQ-1:0]  = mode_q;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_shaper.sv
module gpio_irq_shaper
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] lvl,
  input  logic [NUM_IRQ-1:0] pol,
  input  logic [NUM_IRQ-1:0] both,
  output logic [NUM_IRQ-1:0] edge_evt,
  output logic [NUM_IRQ-1:0] irq_q
);

  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] irq_d;

  generate
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
      assign irq_d[n] = f_irq_next(both[n], pol[n], lvl[n], prev_q[n]);
    end
  endgenerate

  assign edge_evt = lvl ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irq_q  <= '0;
    end else begin
      prev_q <= lvl;
      irq_q  <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned NUM_IRQ     = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_IRQ-1:0]  irq_out
);

  // Named internal events, visible to the bound checker
  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] dir_bits;
  logic [NUM_PINS-1:0] out_bits;
  logic [NUM_IRQ-1:0]  mode_bits;
  logic [NUM_IRQ-1:0]  edge_evt;

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_lvl)
  );

  gpio_regs #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .in_lvl (sync_lvl),
    .dir_q  (dir_bits),
    .out_q  (out_bits),
    .mode_q (mode_bits)
  );

  gpio_irq_shaper #(
    .NUM_IRQ (NUM_IRQ)
  ) u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (sync_lvl[NUM_IRQ-1:0]),
    .pol      (out_bits[NUM_IRQ-1:0]),
    .both     (mode_bits),
    .edge_evt (edge_evt),
    .irq_q    (irq_out)
  );

  assign pad_out = out_bits;
  assign pad_oe  = dir_bits;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BUS_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [BUS_W-1:0]    bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_IRQ-1:0]  irq_out,
  input logic [NUM_IRQ-1:0]  sync_lvl,
  input logic [NUM_IRQ-1:0]  mode_bits,
  input logic [NUM_IRQ-1:0]  edge_evt
);

  logic [31:0] addr_x;
  logic        wr_acc;
  logic        rd_acc;
  assign addr_x = 32'(bus_addr);
  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr_x == OFS_DIR) |=> pad_oe == $past(bus_wdata[NUM_PINS-1:0]));

  assert_set_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr_x == OFS_SET) |=>
      pad_out == ($past(pad_out) | $past(bus_wdata[NUM_PINS-1:0])));

  assert_clr_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr_x == OFS_CLR) |=>
      pad_out == ($past(pad_out) & ~$past(bus_wdata[NUM_PINS-1:0])));

  assert_mode_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && addr_x == OFS_MODE) |-> (bus_rdata >> NUM_IRQ) == '0);

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && f_decode(addr_x) == SEL_NONE) |-> bus_rdata == '0);

  generate
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line_chk
      assert_level_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[n] |=> irq_out[n] == ($past(sync_lvl[n]) ^ $past(pad_out[n])));

      assert_both_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits[n] |=> irq_out[n] == ($past(sync_lvl[n]) ^ $past(sync_lvl[n], 2)));

      assert_edge_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[n] && edge_evt[n]) |=> irq_out[n]);
    end
  endgenerate

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_IRQ  (NUM_IRQ),
  .ADDR_W   (ADDR_W),
  .BUS_W    (BUS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_out   (irq_out),
  .sync_lvl  (sync_lvl[NUM_IRQ-1:0]),
  .mode_bits (mode_bits),
  .edge_evt  (edge_evt)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [15:0] irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after the write edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Combinational read, no clock edge consumed
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(8'h00, d); chk("R1 dir after reset", d, 32'h0);
    bus_read(8'h10, d); chk("R1 out after reset", d, 32'h0);
    bus_read(8'h30, d); chk("R1 mode after reset", d, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_dir_out;
    logic [31:0] d;
    bus_write(8'h00, 32'hA5A5_0F0F);
    bus_read(8'h00, d); chk("R2 dir readback", d, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hA5A5_0F0F);
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h10, d); chk("R4 out readback", d, 32'h1234_5678);
    chk("R4 pad_out", pad_out, 32'h1234_5678);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    bus_write(8'h18, 32'h0000_FF00);
    bus_read(8'h10, d); chk("R5 set alias", d, 32'h1234_FF78);
    bus_read(8'h18, d); chk("R5 set reads zero", d, 32'h0);
    bus_write(8'h20, 32'hFFFF_0000);
    bus_read(8'h10, d); chk("R6 clear alias", d, 32'h0000_FF78);
    chk("R6 pad_out", pad_out, 32'h0000_FF78);
    bus_read(8'h20, d); chk("R6 clear reads zero", d, 32'h0);
    bus_write(8'h10, 32'h0);
    bus_write(8'h00, 32'h0);
  endtask

  task automatic t_input_sync;
    logic [31:0] d;
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_read(8'h08, d); chk("R3 one edge: old value", d, 32'h0);
    @(negedge clk);
    bus_read(8'h08, d); chk("R3 two edges: new value", d, 32'hDEAD_BEEF);
    bus_write(8'h08, 32'h0);
    bus_read(8'h08, d); chk("R3 write ignored", d, 32'hDEAD_BEEF);
    bus_read(8'h10, d); chk("R3 write leaves out", d, 32'h0);
    pad_in = 32'h0;
    settle(4);
  endtask

  task automatic t_mode_reg;
    logic [31:0] d;
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_read(8'h30, d); chk("R7 mode width", d, 32'h0000_FFFF);
    bus_write(8'h30, 32'h0);
    settle(2);
  endtask

  task automatic t_level;
    pad_in = 32'h0000_0005;
    settle(2);
    chk("R8 irq before latency", {16'h0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R8 irq follows pin", {16'h0, irq_out}, 32'h0000_0005);
    bus_write(8'h10, 32'h0000_00FF);
    chk("R9 polarity one edge later", {16'h0, irq_out}, 32'h0000_0005);
    @(negedge clk);
    chk("R9 inverted lines", {16'h0, irq_out}, 32'h0000_00FA);
    pad_in = 32'h0;
    settle(3);
    chk("R9 inverted low pins", {16'h0, irq_out}, 32'h0000_00FF);
    bus_write(8'h10, 32'h0);
    settle(2);
    chk("R8 back to idle", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_both_edge;
    logic [5:0] samp;
    bus_write(8'h30, 32'h0000_0008);
    for (int k = 0; k < 3; k++) begin
      chk("R10 no pulse on mode entry", {16'h0, irq_out}, 32'h0);
      @(negedge clk);
    end
    bus_write(8'h10, 32'h0000_0008);
    settle(2);
    chk("R10 polarity ignored", {16'h0, irq_out}, 32'h0);
    pad_in = 32'h0000_0008;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      samp[k] = irq_out[3];
    end
    chk("R10 rise pulse", {26'h0, samp}, 32'h0000_0004);
    pad_in = 32'h0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      samp[k] = irq_out[3];
    end
    chk("R10 fall pulse", {26'h0, samp}, 32'h0000_0004);
    bus_write(8'h30, 32'h0);
    bus_write(8'h10, 32'h0);
    settle(2);
  endtask

  task automatic t_upper_pins;
    bus_write(8'h10, 32'h00F0_0000);
    for (int k = 0; k < 6; k++) begin
      pad_in = (k % 2 == 0) ? 32'hFFFF_0000 : 32'h5A5A_0000;
      @(negedge clk);
      chk("R11 upper pins silent", {16'h0, irq_out}, 32'h0);
    end
    pad_in = 32'h0;
    bus_write(8'h10, 32'h0);
    settle(3);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_1111);
    bus_write(8'h10, 32'h0000_2222);
    bus_write(8'h30, 32'h0000_3333);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_write(8'h34, 32'hFFFF_FFFF);
    bus_read(8'h04, d); chk("R12 read 0x04", d, 32'h0);
    bus_read(8'h28, d); chk("R12 read 0x28", d, 32'h0);
    bus_read(8'h38, d); chk("R12 read 0x38", d, 32'h0);
    bus_read(8'h00, d); chk("R12 dir kept", d, 32'h0000_1111);
    bus_read(8'h10, d); chk("R12 out kept", d, 32'h0000_2222);
    bus_read(8'h30, d); chk("R12 mode kept", d, 32'h0000_3333);
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'h0);
    bus_write(8'h30, 32'h0);
    settle(3);
  endtask

  task automatic t_collision;
    logic [2:0] samp;
    // Pin rises and polarity sets on the same edge: line stays low
    pad_in = 32'h1;
    @(negedge clk);
    bus_write(8'h10, 32'h1);
    for (int k = 0; k < 3; k++) begin
      samp[k] = irq_out[0];
      @(negedge clk);
    end
    chk("R13 rise with polarity set", {29'h0, samp}, 32'h0);
    // Pin falls and polarity clears on the same edge: line stays low
    pad_in = 32'h0;
    @(negedge clk);
    bus_write(8'h10, 32'h0);
    for (int k = 0; k < 3; k++) begin
      samp[k] = irq_out[0];
      @(negedge clk);
    end
    chk("R13 fall with polarity clear", {29'h0, samp}, 32'h0);
    // Pin rises on the edge that enables both-edge mode: one pulse
    pad_in = 32'h1;
    @(negedge clk);
    bus_write(8'h30, 32'h1);
    for (int k = 0; k < 3; k++) begin
      samp[k] = irq_out[0];
      @(negedge clk);
    end
    chk("R13 edge on mode entry", {29'h0, samp}, 32'h0000_0002);
    bus_write(8'h30, 32'h0);
    pad_in = 32'h0;
    settle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_alias();
    t_input_sync();
    t_mode_reg();
    t_level();
    t_both_edge();
    t_upper_pins();
    t_unmapped();
    t_collision();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule